// File: doc/BRIEF.md
# Oscillator Frequency Recovery Trimmer

This block measures a free-running on-chip oscillator against a slow reference sync pulse and, if asked to, nudges the oscillator's 6-bit trim code toward the target frequency. The whole block runs on the oscillator clock. It counts oscillator cycles between sync events with a reload counter. At each event it captures how far the count missed zero and in which direction. It then sorts that error into one of three bands against a programmable limit and, with auto-trim enabled, steps the trim code by one or two. The trim code saturates at its ends.

There are three sync inputs: a pin, a low-speed crystal tick and a USB start-of-frame pulse. All three are assumed to be already synchronous to the oscillator clock. One input is selected and its active edge is chosen. The edge stream is then divided by a power of two. Software can also inject a sync event by writing a control bit.

A plain register port (write strobe, 2-bit address, 32-bit write data, combinational read data) gives access to control, configuration, status and flag clearing. There is no data stream in this block, so the register port and all pins are plain level signals with no valid/ready handshake. A writer may issue one write per clock. The interrupt output is level-sensitive.

Register map, in 32-bit words:

- CTRL (address 0): bits 3:0 are the interrupt enables for ok, warn, err and esync. Bit 4 is counter enable, bit 5 is auto-trim, bit 6 is the software sync (write-only, reads as 0), and bits 13:8 are trim.
- CFG (address 1): bits 15:0 are reload, bits 23:16 are the limit L, bits 26:24 are the divider code, bits 29:28 are the source, and bit 31 is polarity.
- STAT (address 2, read-only): bit 0 is ok, bit 1 warn, bit 2 err, bit 3 esync, bit 8 sync-error, bit 9 miss, bit 10 trim-overflow, bit 15 direction, and bits 31:16 hold the captured magnitude.
- CLR (address 3, write-one-to-clear): bit 0 clears ok, bit 1 clears warn, bit 2 clears err (sync-error, miss and overflow together), and bit 3 clears esync.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset CTRL reads 0x00002000 (trim 32, everything else off), CFG reads 0x2022BB7F (reload 0xBB7F, limit 0x22, divide code 0, source 2 = start-of-frame, rising edge), STAT reads 0, trim_o is 32 and irq_o is 0.
- R2: With the counter enabled, the counter loads reload, then counts down one per clock. In the clock where it is 0 while counting down and no sync arrives, esync (STAT bit 3) sets and counting turns upward. At each sync event the counter's current value goes to STAT[31:16], and STAT bit 15 gets 1 if the counter was counting down (oscillator slow) or 0 if it was counting up (oscillator fast). The counter then reloads and counts down again.
- R3: With limit L, an evaluated sync with captured magnitude below L sets ok (bit 0). A magnitude of at least L but below 3L sets warn (bit 1). A magnitude of 3L or more sets sync-error (bit 8).
- R4: If the upward count reaches 3L with no sync, miss (bit 9) sets and the counter freezes. The next sync only reloads it: capture, direction, band flags and trim are all left unchanged.
- R5: With auto-trim on, an evaluated sync leaves trim alone in the ok band, steps it by 1 in the warn band and by 2 in the sync-error band. The step is upward when direction is 1 and downward when it is 0. With auto-trim off, syncs never change trim.
- R6: A trim step that would go above 63 or below 0 leaves trim at 63 or 0 and sets trim-overflow (bit 10).
- R7: While counter enable is 1, writes to CFG are ignored. Once it is 0, they take effect.
- R8: While auto-trim is 1, the trim field of a CTRL write is ignored.
- R9: Source code 0 selects the pin, 1 the crystal tick and 2 the start-of-frame pulse. An unselected input has no effect. With polarity bit 0 the rising edge is active, and with bit 1 the falling edge is active.
- R10: Divider code n produces one sync event on every 2^n-th active edge of the selected input.
- R11: Writing CTRL with bit 6 set produces a sync event in that clock, with no divider applied.
- R12: The err bit (bit 2) is the OR of sync-error, miss and trim-overflow. Writing 1 to a CLR bit clears the corresponding flag or flags. A flag that is set and cleared in the same clock stays set.
- R13: irq_o is 1 exactly when one of ok, warn, err or esync is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin_i | input | 1 | Sync from a pin (source 0) |
| sync_xtal_i | input | 1 | Low-speed crystal tick (source 1) |
| sync_sof_i | input | 1 | USB start-of-frame pulse (source 2) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| trim_o | output | 6 | Trim code to the oscillator |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps the sync spacing across every error magnitude on both sides of zero, for a small reload and limit. This covers the exact ok/warn and warn/sync-error boundaries, the zero-error clock where esync must not fire, and the first spacing that produces a miss. An off-by-one in the band compares or in the reload timing shows up there as the wrong flag or a capture that is off by one. A design that evaluated a sync after a miss would overwrite the capture and move trim.

Trim is driven into both rails. An adder that wraps instead of saturating would read 0 or 63 on the wrong side. The bench also aims at the write locks, the polarity, source and divide selection, and the grouped error clear. Each of these would, if wrong, produce a spurious or missing flag that the bench reads at the register port.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_CLR  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_SOF  = 2'd2,
    SRC_NONE = 2'd3
  } sync_src_e;

  typedef enum logic [1:0] {
    BAND_OK   = 2'd0,
    BAND_WARN = 2'd1,
    BAND_ERR  = 2'd2
  } err_band_e;
endpackage

// File: rtl/sync_front.sv
module sync_front import osc_trim_pkg::*; #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       src,
  input  logic             pol,
  input  logic [DIV_W-1:0] div,
  input  logic             pin,
  input  logic             xtal,
  input  logic             sof,
  input  logic             sw_sync,
  output logic             evt
);
  localparam int PW = (1 << DIV_W) - 1;

  logic          sel, lvl, lvl_q, act_edge, hit;
  logic [PW-1:0] pcnt_q, mask;

  always_comb begin
    unique case (sync_src_e'(src))
      SRC_PIN:  sel = pin;
      SRC_XTAL: sel = xtal;
      SRC_SOF:  sel = sof;
      default:  sel = 1'b0;
    endcase
  end

  assign lvl      = sel ^ pol;
  assign act_edge = lvl & ~lvl_q;
  assign mask     = ~({PW{1'b1}} << div);
  assign hit      = ((pcnt_q & mask) == mask);
  assign evt      = sw_sync | (en & act_edge & hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      pcnt_q <= '0;
    end else begin
      lvl_q <= lvl;
      if (!en)           pcnt_q <= '0;
      else if (act_edge) pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic [CNT_W-1:0] reload,
  input  logic [LIM_W-1:0] lim,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             stop_o,
  output logic             eval_o,
  output logic             esync_set_o,
  output logic             miss_set_o
);
  localparam int L3W = LIM_W + 2;

  logic [CNT_W-1:0] cnt_q, lim3;
  logic             up_q, stop_q, run;

  assign lim3        = CNT_W'({2'b00, lim} + {1'b0, lim, 1'b0});
  assign run         = en & ~evt & ~stop_q;
  assign esync_set_o = run & ~up_q & (cnt_q == '0);
  assign miss_set_o  = run & up_q & ((cnt_q == lim3) | (&cnt_q));
  assign eval_o      = en & evt & ~stop_q;
  assign cnt_o       = cnt_q;
  assign up_o        = up_q;
  assign stop_o      = stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (!en || evt) begin
      cnt_q  <= reload;
      up_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (esync_set_o) begin
      cnt_q <= CNT_W'(1);
      up_q  <= 1'b1;
    end else if (miss_set_o) begin
      stop_q <= 1'b1;
    end else if (!stop_q) begin
      cnt_q <= up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  logic unused_l3w;
  assign unused_l3w = (L3W > CNT_W);
endmodule

// File: rtl/trim_unit.sv
module trim_unit import osc_trim_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int LIM_W  = 8,
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [CNT_W-1:0]  mag,
  input  logic              up,
  input  logic [LIM_W-1:0]  lim,
  input  logic              auto_en,
  input  logic              sw_we,
  input  logic [TRIM_W-1:0] sw_val,
  output logic [TRIM_W-1:0] trim_o,
  output err_band_e         band_o,
  output logic              ovf_set_o
);
  localparam logic [TRIM_W:0]   TMAX     = (TRIM_W+1)'((1 << TRIM_W) - 1);
  localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(1 << (TRIM_W - 1));

  logic [TRIM_W-1:0] trim_q, nxt;
  logic [TRIM_W:0]   sum, stepx;
  logic [1:0]        step;
  logic [CNT_W-1:0]  lim_x, lim3_x;
  logic              ovf;

  assign lim_x  = CNT_W'(lim);
  assign lim3_x = CNT_W'({2'b00, lim} + {1'b0, lim, 1'b0});

  always_comb begin
    if (mag < lim_x)       begin band_o = BAND_OK;   step = 2'd0; end
    else if (mag < lim3_x) begin band_o = BAND_WARN; step = 2'd1; end
    else                   begin band_o = BAND_ERR;  step = 2'd2; end
    stepx = (TRIM_W+1)'(step);
    sum   = {1'b0, trim_q} + stepx;
    ovf   = 1'b0;
    if (up) begin
      if (stepx > {1'b0, trim_q}) begin nxt = '0; ovf = 1'b1; end
      else nxt = trim_q - TRIM_W'(step);
    end else begin
      if (sum > TMAX) begin nxt = '1; ovf = 1'b1; end
      else nxt = sum[TRIM_W-1:0];
    end
  end

  assign ovf_set_o = eval & auto_en & ovf;
  assign trim_o    = trim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                trim_q <= TRIM_RST;
    else if (eval && auto_en)  trim_q <= nxt;
    else if (sw_we && !auto_en) trim_q <= sw_val;
  end
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl import osc_trim_pkg::*; #(
  parameter int               CNT_W      = 16,
  parameter int               LIM_W      = 8,
  parameter int               TRIM_W     = 6,
  parameter int               DIV_W      = 3,
  parameter logic [CNT_W-1:0] RELOAD_RST = 16'hBB7F,
  parameter logic [LIM_W-1:0] LIM_RST    = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_pin_i,
  input  logic              sync_xtal_i,
  input  logic              sync_sof_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              irq_o
);
  localparam int TRIM_LSB = 8;
  localparam int LIM_LSB  = 16;
  localparam int DIV_LSB  = 24;
  localparam int SRC_LSB  = 28;
  localparam int CAP_LSB  = 16;

  logic [3:0]       ie_q;
  logic             cnt_en_q, auto_q;
  logic [CNT_W-1:0] reload_q, cap_q, cnt_w;
  logic [LIM_W-1:0] lim_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       src_q;
  logic             pol_q;
  logic             ok_q, warn_q, esync_q, serr_q, miss_q, ovf_q, dir_q;
  logic             wr_ctrl, wr_cfg, sw_sync, evt_w, up_w, stop_w, eval_w;
  logic             esync_set, miss_set, ovf_set, err_w;
  logic [3:0]       clr_w;
  logic             clr_ok_w;
  err_band_e        band_w;
  logic [31:0]      ctrl_rd, cfg_rd, stat_rd;
  logic [TRIM_W-1:0] trim_w;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_cfg   = reg_we_i && (reg_addr_i == ADDR_CFG);
  assign clr_w    = (reg_we_i && (reg_addr_i == ADDR_CLR)) ? reg_wdata_i[3:0] : 4'b0000;
  assign clr_ok_w = clr_w[0];
  assign sw_sync  = wr_ctrl & reg_wdata_i[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      cnt_en_q <= 1'b0;
      auto_q   <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q     <= reg_wdata_i[3:0];
      cnt_en_q <= reg_wdata_i[4];
      auto_q   <= reg_wdata_i[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      lim_q    <= LIM_RST;
      div_q    <= '0;
      src_q    <= SRC_SOF;
      pol_q    <= 1'b0;
    end else if (wr_cfg && !cnt_en_q) begin
      reload_q <= reg_wdata_i[CNT_W-1:0];
      lim_q    <= reg_wdata_i[LIM_LSB +: LIM_W];
      div_q    <= reg_wdata_i[DIV_LSB +: DIV_W];
      src_q    <= reg_wdata_i[SRC_LSB +: 2];
      pol_q    <= reg_wdata_i[31];
    end
  end

  sync_front #(.DIV_W(DIV_W)) u_front (
    .clk(clk), .rst_n(rst_n), .en(cnt_en_q), .src(src_q), .pol(pol_q),
    .div(div_q), .pin(sync_pin_i), .xtal(sync_xtal_i), .sof(sync_sof_i),
    .sw_sync(sw_sync), .evt(evt_w)
  );

  err_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en_q), .evt(evt_w), .reload(reload_q),
    .lim(lim_q), .cnt_o(cnt_w), .up_o(up_w), .stop_o(stop_w), .eval_o(eval_w),
    .esync_set_o(esync_set), .miss_set_o(miss_set)
  );

  trim_unit #(.CNT_W(CNT_W), .LIM_W(LIM_W), .TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .eval(eval_w), .mag(cnt_w), .up(up_w),
    .lim(lim_q), .auto_en(auto_q), .sw_we(wr_ctrl),
    .sw_val(reg_wdata_i[TRIM_LSB +: TRIM_W]), .trim_o(trim_w),
    .band_o(band_w), .ovf_set_o(ovf_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0; warn_q <= 1'b0; esync_q <= 1'b0;
      serr_q <= 1'b0; miss_q <= 1'b0; ovf_q <= 1'b0;
      cap_q <= '0; dir_q <= 1'b0;
    end else begin
      ok_q    <= (eval_w && band_w == BAND_OK)   | (ok_q    & ~clr_w[0]);
      warn_q  <= (eval_w && band_w == BAND_WARN) | (warn_q  & ~clr_w[1]);
      serr_q  <= (eval_w && band_w == BAND_ERR)  | (serr_q  & ~clr_w[2]);
      miss_q  <= miss_set                        | (miss_q  & ~clr_w[2]);
      ovf_q   <= ovf_set                         | (ovf_q   & ~clr_w[2]);
      esync_q <= esync_set                       | (esync_q & ~clr_w[3]);
      if (eval_w) begin
        cap_q <= cnt_w;
        dir_q <= ~up_w;
      end
    end
  end

  assign err_w   = serr_q | miss_q | ovf_q;
  assign ctrl_rd = {18'd0, 2'b00, trim_w, 1'b0, 1'b0, auto_q, cnt_en_q, ie_q};
  assign cfg_rd  = {pol_q, 1'b0, src_q, 1'b0, div_q, lim_q, reload_q};
  assign stat_rd = {cap_q, dir_q, 4'd0, ovf_q, miss_q, serr_q, 4'd0,
                    esync_q, err_w, warn_q, ok_q};

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CTRL: reg_rdata_o = ctrl_rd;
      ADDR_CFG:  reg_rdata_o = cfg_rd;
      ADDR_STAT: reg_rdata_o = stat_rd;
      default:   reg_rdata_o = 32'd0;
    endcase
  end

  assign trim_o = trim_w;
  assign irq_o  = |({esync_q, err_w, warn_q, ok_q} & ie_q);

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:CNT_W], reg_wdata_i[15:14],
                          reg_wdata_i[7], reg_wdata_i[6:0]};
endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk #(
  parameter int CNT_W  = 16,
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              auto_en,
  input logic [31:0]       cfg_word,
  input logic [TRIM_W-1:0] trim,
  input logic              evt,
  input logic              eval,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              up,
  input logic              stop,
  input logic              esync,
  input logic              clr_ok,
  input logic              ok,
  input logic [3:0]        ie,
  input logic              irq
);
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> $stable(cfg_word)); // R7

  AST_TRIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |=> (({2'b00, trim} + 2'd2 >= {2'b00, $past(trim)}) &&
                 ({2'b00, trim} <= {2'b00, $past(trim)} + 2'd2))); // R5

  AST_RELOAD_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && evt) |=> (cnt == $past(reload))); // R2

  AST_ESYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !evt && !stop && !up && cnt == '0) |=> esync); // R2

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && stop && !evt) |=> $stable(cnt)); // R4

  AST_OK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !eval) |=> !ok); // R12

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 4'b0000) |-> !irq); // R13
endmodule

bind osc_trim_ctrl osc_trim_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en_q), .auto_en(auto_q),
  .cfg_word(cfg_rd), .trim(trim_w), .evt(evt_w), .eval(eval_w), .cnt(cnt_w),
  .reload(reload_q), .up(up_w), .stop(stop_w), .esync(esync_q),
  .clr_ok(clr_ok_w), .ok(ok_q), .ie(ie_q), .irq(irq_o)
);

// File: tb/osc_trim_ctrl_tb.sv
module osc_trim_ctrl_tb;
  localparam int RL = 20;
  localparam int LM = 2;
  localparam logic [31:0] EN = 32'h10, AUTO = 32'h20, SWS = 32'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, xtal = 1'b0, sof = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = 32'd0, rdata;
  logic [5:0] trim;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] ctrl_sh = 32'h2000;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osc_trim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sync_pin_i(pin), .sync_xtal_i(xtal),
    .sync_sof_i(sof), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .trim_o(trim), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    if (a == 2'd0) ctrl_sh = d & ~SWS;
    @(negedge clk);
    we = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic setup(input logic [31:0] cfg, input int t, input bit au, input logic [3:0] ie);
    wr(2'd0, 32'(t) << 8);
    wr(2'd3, 32'hF);
    wr(2'd1, cfg);
    wr(2'd0, EN | (au ? AUTO : 32'd0) | 32'(ie) | (32'(t) << 8));
  endtask

  task automatic sync_after(input int n);
    repeat (n - 1) @(negedge clk);
    wr(2'd0, ctrl_sh | SWS);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; repeat (2) @(negedge clk);
    s = 1'b0; repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] CFG_T = (32'(LM) << 16) | 32'(RL) | (32'd2 << 28);

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, cap_e, st_e, cfg_keep;
    bit dir_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0000_2000);
    rd(2'd1, d); chk("R1 cfg", d, 32'h2022_BB7F);
    rd(2'd2, d); chk("R1 stat", d, 32'd0);
    chk("R1 trim", 32'(trim), 32'd32);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 R3 R4 R5 R11: sweep of sync spacing, software sync
    cap_e = 0; dir_e = 0;
    for (int n = 10; n <= 30; n++) begin
      int el, mag, t, stp;
      bit up, es, ms, ok, wn, se, ov;
      setup(CFG_T, 32, 1'b1, 4'd0);
      sync_after(n);
      el = n - 1;
      up = (el > RL);
      mag = up ? el - RL : RL - el;
      es = up;
      ms = up && (mag > 3 * LM);
      ok = 0; wn = 0; se = 0; ov = 0; t = 32;
      if (!ms) begin
        if (mag < LM) stp = 0;
        else if (mag < 3 * LM) begin stp = 1; wn = 1; end
        else begin stp = 2; se = 1; end
        ok = (mag < LM);
        t = up ? 32 - stp : 32 + stp;
        cap_e = 32'(mag); dir_e = !up;
      end
      st_e = (cap_e << 16) | (32'(dir_e) << 15) | (32'(ov) << 10) | (32'(ms) << 9)
           | (32'(se) << 8) | (32'(es) << 3) | (32'(se | ms | ov) << 2)
           | (32'(wn) << 1) | 32'(ok);
      rd(2'd2, d); chk("R2 R3 R4 R11 stat sweep", d, st_e);
      chk("R5 trim sweep", 32'(trim), 32'(t));
    end

    // R5 auto-trim off leaves trim
    setup(CFG_T, 32, 1'b0, 4'd0);
    sync_after(10);
    rd(2'd2, d); chk("R3 err band no auto", d & 32'h107, 32'h104 | 32'h100);
    chk("R5 trim fixed without auto", 32'(trim), 32'd32);

    // R6 saturation at top
    setup(CFG_T, 62, 1'b1, 4'd0);
    sync_after(10);
    chk("R6 trim top", 32'(trim), 32'd63);
    rd(2'd2, d); chk("R6 ovf top", d & 32'h404, 32'h404);
    sync_after(10);
    chk("R6 trim stays top", 32'(trim), 32'd63);
    // R6 saturation at bottom
    setup(CFG_T, 1, 1'b1, 4'd0);
    sync_after(27);
    chk("R6 trim bottom", 32'(trim), 32'd0);
    rd(2'd2, d); chk("R6 ovf bottom", d & 32'h504, 32'h504);

    // R12 grouped error clear keeps esync
    wr(2'd3, 32'h4);
    rd(2'd2, d); chk("R12 err clear", d & 32'h70F, 32'h008);

    // R8 trim writes ignored under auto
    wr(2'd0, EN | AUTO | (32'd5 << 8));
    rd(2'd0, d); chk("R8 trim locked", (d >> 8) & 32'h3F, 32'd0);

    // R7 config locked while counting
    rd(2'd1, cfg_keep);
    wr(2'd1, 32'h0000_1234);
    rd(2'd1, d); chk("R7 cfg locked", d, cfg_keep);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h0000_1234);
    rd(2'd1, d); chk("R7 cfg open", d, 32'h0000_1234);

    // R13 interrupt and R12 ok clear
    setup(CFG_T, 32, 1'b0, 4'b0001);
    sync_after(21);
    chk("R13 irq on", 32'(irq), 32'd1);
    wr(2'd0, EN | (32'd32 << 8));
    chk("R13 irq masked", 32'(irq), 32'd0);
    wr(2'd3, 32'h1);
    rd(2'd2, d); chk("R12 ok cleared", d & 32'h1, 32'd0);

    // R10 divide by 4 on pin
    setup((32'd2 << 24) | (32'd2 << 16) | 32'd1000, 32, 1'b0, 4'd0);
    repeat (3) pulse(pin);
    rd(2'd2, d); chk("R10 no event before 4th", d & 32'h103, 32'd0);
    pulse(pin);
    rd(2'd2, d); chk("R10 event on 4th", d & 32'h103, 32'h100);

    // R9 falling polarity
    setup((32'd1 << 31) | (32'd2 << 16) | 32'd1000, 32, 1'b0, 4'd0);
    pin = 1'b1; repeat (3) @(negedge clk);
    rd(2'd2, d); chk("R9 rise ignored", d & 32'h103, 32'd0);
    pin = 1'b0; repeat (2) @(negedge clk);
    rd(2'd2, d); chk("R9 fall active", d & 32'h103, 32'h100);

    // R9 source select
    setup((32'd1 << 28) | (32'd2 << 16) | 32'd1000, 32, 1'b0, 4'd0);
    pulse(pin);
    rd(2'd2, d); chk("R9 pin unselected", d & 32'h103, 32'd0);
    pulse(xtal);
    rd(2'd2, d); chk("R9 xtal selected", d & 32'h103, 32'h100);
    setup((32'd2 << 28) | (32'd2 << 16) | 32'd1000, 32, 1'b0, 4'd0);
    pulse(sof);
    rd(2'd2, d); chk("R9 sof selected", d & 32'h103, 32'h100);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule